// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block watches the decode, execute and writeback stages of a four-stage in-order pipeline and decides, every cycle, whether the front of the pipe must wait. Each stage reports a small status vector: whether it holds a valid instruction, which register it will write, whether it is a load, and which kinds of CSR access it performs. Decode also reports the registers it reads, whether it is a register-indirect jump, and whether it reads CSR state implicitly. Register-indirect jumps are resolved in decode and need their target register early. Conditional branches are resolved in execute and do not appear here.

The controller is purely combinational from these inputs. A decode-side hazard holds fetch and decode and puts an empty slot into execute. An execute-side hazard holds fetch, decode and execute and puts an empty slot into writeback. A three-bit cause code reports which rule fired, for use by performance counters or debug logic elsewhere. Multi-cycle penalties arise naturally: a held instruction keeps asserting its hazard until the producer has moved far enough down the pipe.

Top module: `hazard_ctl`

## Requirements
- R1: A valid decode instruction that reads (rs1 or rs2, each with its enable) the destination of a valid load in execute causes a decode stall: hold_if=1, stall_id=1, bubble_ex=1, stall_ex=0, bubble_wb=0, cause=1.
- R2: A valid register-indirect jump in decode whose rs1 matches the destination of a valid non-load in execute stalls decode with cause=2. A matching non-load in writeback causes no stall.
- R3: A valid register-indirect jump whose rs1 matches the destination of a valid load in execute or in writeback stalls decode with cause=3, so a load directly before the jump costs two cycles.
- R4: A valid decode instruction with an implicit CSR read stalls decode with cause=4 while execute or writeback holds a valid instruction with any CSR access (explicit or implicit, read or write). This gives two cycles when the access is in execute.
- R5: A valid execute instruction with an implicit CSR read stalls execute with cause=5 while writeback holds a valid instruction with any CSR access.
- R6: A valid execute instruction with an explicit CSR read stalls execute with cause=6 when writeback holds a valid implicit CSR write, or a valid explicit CSR write to an equal CSR address. An explicit write to a different address causes no stall.
- R7: A destination register of 0 never produces a data hazard (R1 to R3).
- R8: An execute stall drives hold_if=1, stall_id=1, stall_ex=1, bubble_wb=1, bubble_ex=0. Cause priority is 5, 6, 3, 2, 4, 1, from highest to lowest.
- R9: With no hazard, or with the stage valid flags low, all stall and bubble outputs are 0 and cause=0, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset, used by the embedded checks |
| id_valid | input | 1 | Decode holds an instruction |
| id_rs1_en | input | 1 | Decode reads rs1 |
| id_rs1 | input | REG_AW | Decode rs1 index (also the jump base) |
| id_rs2_en | input | 1 | Decode reads rs2 |
| id_rs2 | input | REG_AW | Decode rs2 index |
| id_jreg | input | 1 | Decode is a register-indirect jump |
| id_csr_ird | input | 1 | Decode reads CSR state implicitly |
| ex_valid | input | 1 | Execute holds an instruction |
| ex_rd | input | REG_AW | Execute destination (0 = none) |
| ex_load | input | 1 | Execute instruction is a load |
| ex_csr_erd | input | 1 | Execute explicit CSR read |
| ex_csr_ewr | input | 1 | Execute explicit CSR write |
| ex_csr_ird | input | 1 | Execute implicit CSR read |
| ex_csr_iwr | input | 1 | Execute implicit CSR write |
| ex_csr_addr | input | CSR_AW | Execute CSR address |
| wb_valid | input | 1 | Writeback holds an instruction |
| wb_rd | input | REG_AW | Writeback destination (0 = none) |
| wb_load | input | 1 | Writeback instruction is a load |
| wb_csr_erd | input | 1 | Writeback explicit CSR read |
| wb_csr_ewr | input | 1 | Writeback explicit CSR write |
| wb_csr_ird | input | 1 | Writeback implicit CSR read |
| wb_csr_iwr | input | 1 | Writeback implicit CSR write |
| wb_csr_addr | input | CSR_AW | Writeback CSR address |
| hold_if | output | 1 | Hold fetch |
| stall_id | output | 1 | Hold decode |
| stall_ex | output | 1 | Hold execute |
| bubble_ex | output | 1 | Insert an empty slot into execute |
| bubble_wb | output | 1 | Insert an empty slot into writeback |
| cause | output | 3 | Hazard class code (0 none, 1 to 6 per R1 to R6) |

## Verification
The bench builds the controller with REG_AW=2 and CSR_AW=2. With four registers and four CSR addresses, random status vectors hit register matches, x0 destinations and CSR address matches and mismatches in a large share of cycles. Tens of thousands of vectors therefore cover every rule, every overlap between rules and so every priority case. Directed cycle sequences add the multi-cycle penalties: a load followed by a jump, and a CSR access followed by an implicit reader, stepping through the pipe.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int REG_AW = 5,
  parameter int CSR_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic              id_rs1_en,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs2_en,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_jreg,
  input  logic              id_csr_ird,
  input  logic              ex_valid,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_load,
  input  logic              ex_csr_erd,
  input  logic              ex_csr_ewr,
  input  logic              ex_csr_ird,
  input  logic              ex_csr_iwr,
  input  logic [CSR_AW-1:0] ex_csr_addr,
  input  logic              wb_valid,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_load,
  input  logic              wb_csr_erd,
  input  logic              wb_csr_ewr,
  input  logic              wb_csr_ird,
  input  logic              wb_csr_iwr,
  input  logic [CSR_AW-1:0] wb_csr_addr,
  output logic              hold_if,
  output logic              stall_id,
  output logic              stall_ex,
  output logic              bubble_ex,
  output logic              bubble_wb,
  output logic [2:0]        cause
);

  localparam logic [2:0] C_NONE = 3'd0;
  localparam logic [2:0] C_LU   = 3'd1;
  localparam logic [2:0] C_JA   = 3'd2;
  localparam logic [2:0] C_JL   = 3'd3;
  localparam logic [2:0] C_IC   = 3'd4;
  localparam logic [2:0] C_XI   = 3'd5;
  localparam logic [2:0] C_XE   = 3'd6;

  logic ex_wr, wb_wr;
  logic rs1_ex, rs2_ex, jr_ex, jr_wb;
  logic ex_csr_any, wb_csr_any, csr_same;
  logic h_lu, h_ja, h_jl, h_ic, h_xi, h_xe;
  logic id_haz, ex_haz;

  assign ex_wr = ex_valid && (ex_rd != '0);
  assign wb_wr = wb_valid && (wb_rd != '0);

  assign rs1_ex = id_rs1_en && ex_wr && (id_rs1 == ex_rd);
  assign rs2_ex = id_rs2_en && ex_wr && (id_rs2 == ex_rd);
  assign jr_ex  = ex_wr && (id_rs1 == ex_rd);
  assign jr_wb  = wb_wr && (id_rs1 == wb_rd);

  assign ex_csr_any = ex_valid && (ex_csr_erd || ex_csr_ewr || ex_csr_ird || ex_csr_iwr);
  assign wb_csr_any = wb_valid && (wb_csr_erd || wb_csr_ewr || wb_csr_ird || wb_csr_iwr);
  assign csr_same   = (ex_csr_addr == wb_csr_addr);

  assign h_lu = id_valid && ex_load && (rs1_ex || rs2_ex);
  assign h_jl = id_valid && id_jreg && ((jr_ex && ex_load) || (jr_wb && wb_load));
  assign h_ja = id_valid && id_jreg && jr_ex && !ex_load;
  assign h_ic = id_valid && id_csr_ird && (ex_csr_any || wb_csr_any);
  assign h_xi = ex_valid && ex_csr_ird && wb_csr_any;
  assign h_xe = ex_valid && ex_csr_erd && wb_valid &&
                (wb_csr_iwr || (wb_csr_ewr && csr_same));

  assign ex_haz = h_xi || h_xe;
  assign id_haz = h_lu || h_ja || h_jl || h_ic;

  assign stall_ex  = ex_haz;
  assign stall_id  = ex_haz || id_haz;
  assign hold_if   = stall_id;
  assign bubble_wb = ex_haz;
  assign bubble_ex = id_haz && !ex_haz;

  always_comb begin
    if (h_xi)      cause = C_XI;
    else if (h_xe) cause = C_XE;
    else if (h_jl) cause = C_JL;
    else if (h_ja) cause = C_JA;
    else if (h_ic) cause = C_IC;
    else if (h_lu) cause = C_LU;
    else           cause = C_NONE;
  end

  // R1: load feeding the next instruction holds decode
  p_load_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && ex_valid && ex_load && ex_rd != '0 &&
     ((id_rs1_en && id_rs1 == ex_rd) || (id_rs2_en && id_rs2 == ex_rd)))
    |-> (stall_id && hold_if));

  // R3: jump base produced by a load in writeback still holds decode
  p_jreg_load_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_jreg && wb_valid && wb_load && wb_rd != '0 && id_rs1 == wb_rd)
    |-> stall_id);

  // R4: implicit CSR reader in decode waits for any CSR access ahead
  p_csr_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_csr_ird && ex_valid && (ex_csr_erd || ex_csr_ewr))
    |-> stall_id);

  // R6: explicit write to another address does not hold an explicit reader
  p_csr_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_valid && ex_csr_erd && !ex_csr_ird && wb_valid && !wb_csr_iwr &&
     ex_csr_addr != wb_csr_addr) |-> !stall_ex);

  // R7: no register hazard on x0
  p_x0_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0 && wb_rd == '0 && !id_csr_ird && !ex_csr_ird && !ex_csr_erd)
    |-> (!stall_id && cause == 3'd0));

  // R8: execute stall holds everything before it and empties writeback only
  p_ex_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ex |-> (stall_id && hold_if && bubble_wb && !bubble_ex && cause >= 3'd5));

  // R9: outputs quiet when no stage holds an instruction
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid && !ex_valid) |-> (!stall_id && !bubble_wb && cause == 3'd0));

endmodule

// File: tb/hazard_ctl_tb_top.sv
module hazard_ctl_tb_top;
  localparam int RA = 2;
  localparam int CA = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          id_valid, id_rs1_en, id_rs2_en, id_jreg, id_csr_ird;
  logic [RA-1:0] id_rs1, id_rs2, ex_rd, wb_rd;
  logic          ex_valid, ex_load, ex_csr_erd, ex_csr_ewr, ex_csr_ird, ex_csr_iwr;
  logic          wb_valid, wb_load, wb_csr_erd, wb_csr_ewr, wb_csr_ird, wb_csr_iwr;
  logic [CA-1:0] ex_csr_addr, wb_csr_addr;
  logic          hold_if, stall_id, stall_ex, bubble_ex, bubble_wb;
  logic [2:0]    cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  hazard_ctl #(.REG_AW(RA), .CSR_AW(CA)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .id_valid(id_valid), .id_rs1_en(id_rs1_en), .id_rs1(id_rs1),
    .id_rs2_en(id_rs2_en), .id_rs2(id_rs2), .id_jreg(id_jreg), .id_csr_ird(id_csr_ird),
    .ex_valid(ex_valid), .ex_rd(ex_rd), .ex_load(ex_load),
    .ex_csr_erd(ex_csr_erd), .ex_csr_ewr(ex_csr_ewr), .ex_csr_ird(ex_csr_ird),
    .ex_csr_iwr(ex_csr_iwr), .ex_csr_addr(ex_csr_addr),
    .wb_valid(wb_valid), .wb_rd(wb_rd), .wb_load(wb_load),
    .wb_csr_erd(wb_csr_erd), .wb_csr_ewr(wb_csr_ewr), .wb_csr_ird(wb_csr_ird),
    .wb_csr_iwr(wb_csr_iwr), .wb_csr_addr(wb_csr_addr),
    .hold_if(hold_if), .stall_id(stall_id), .stall_ex(stall_ex),
    .bubble_ex(bubble_ex), .bubble_wb(bubble_wb), .cause(cause)
  );

  task automatic clear();
    {id_valid, id_rs1_en, id_rs2_en, id_jreg, id_csr_ird} = '0;
    {id_rs1, id_rs2, ex_rd, wb_rd} = '0;
    {ex_valid, ex_load, ex_csr_erd, ex_csr_ewr, ex_csr_ird, ex_csr_iwr} = '0;
    {wb_valid, wb_load, wb_csr_erd, wb_csr_ewr, wb_csr_ird, wb_csr_iwr} = '0;
    {ex_csr_addr, wb_csr_addr} = '0;
  endtask

  function automatic logic [7:0] pack_exp(logic [2:0] c);
    logic xs, ds;
    xs = (c == 3'd5) || (c == 3'd6);
    ds = (c != 3'd0);
    return {ds, ds, xs, ds && !xs, xs, c};
  endfunction

  function automatic logic [7:0] model();
    logic r_xi, r_xe, r_jl, r_ja, r_ic, r_lu, wb_any, ex_any;
    logic [2:0] c;
    wb_any = wb_valid & (wb_csr_erd | wb_csr_ewr | wb_csr_ird | wb_csr_iwr);
    ex_any = ex_valid & (ex_csr_erd | ex_csr_ewr | ex_csr_ird | ex_csr_iwr);
    r_xi = ex_valid & ex_csr_ird & wb_any;
    r_xe = 1'b0;
    if (ex_valid && ex_csr_erd && wb_valid) begin
      if (wb_csr_iwr) r_xe = 1'b1;
      if (wb_csr_ewr && wb_csr_addr == ex_csr_addr) r_xe = 1'b1;
    end
    r_jl = 1'b0; r_ja = 1'b0; r_lu = 1'b0;
    if (id_valid && id_jreg) begin
      if (ex_valid && ex_rd != 0 && ex_rd == id_rs1) begin
        if (ex_load) r_jl = 1'b1; else r_ja = 1'b1;
      end
      if (wb_valid && wb_load && wb_rd != 0 && wb_rd == id_rs1) r_jl = 1'b1;
    end
    if (id_valid && ex_valid && ex_load && ex_rd != 0) begin
      if (id_rs1_en && id_rs1 == ex_rd) r_lu = 1'b1;
      if (id_rs2_en && id_rs2 == ex_rd) r_lu = 1'b1;
    end
    r_ic = id_valid & id_csr_ird & (ex_any | wb_any);
    c = r_xi ? 3'd5 : r_xe ? 3'd6 : r_jl ? 3'd3 : r_ja ? 3'd2 :
        r_ic ? 3'd4 : r_lu ? 3'd1 : 3'd0;
    return pack_exp(c);
  endfunction

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] exp);
    logic [7:0] act;
    #1;
    act = {hold_if, stall_id, stall_ex, bubble_ex, bubble_wb, cause};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got if/id/ex/bex/bwb/cause=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] s;
    clear();
    step();
    chk("R9 reset idle", pack_exp(3'd0));
    repeat (2) step();
    rst_n = 1'b1;

    // R1 load-use through rs2
    step(); clear();
    ex_valid = 1; ex_load = 1; ex_rd = 2'd2;
    id_valid = 1; id_rs2_en = 1; id_rs2 = 2'd2;
    chk("R1 load-use rs2", pack_exp(3'd1));
    // R1: same match but rs2 not read -> none
    id_rs2_en = 0;
    chk("R1 unused operand", pack_exp(3'd0));

    // R7 load to x0
    step(); clear();
    ex_valid = 1; ex_load = 1; ex_rd = 2'd0;
    id_valid = 1; id_rs1_en = 1; id_jreg = 1;
    chk("R7 x0 load", pack_exp(3'd0));

    // R2 jump after ALU op in EX, then in WB
    step(); clear();
    ex_valid = 1; ex_rd = 2'd1; id_valid = 1; id_jreg = 1; id_rs1 = 2'd1;
    chk("R2 jreg alu ex", pack_exp(3'd2));
    step(); ex_valid = 0; wb_valid = 1; wb_rd = 2'd1;
    chk("R2 jreg alu wb", pack_exp(3'd0));

    // R3 jump after load: two stalled cycles then release
    step(); clear();
    ex_valid = 1; ex_load = 1; ex_rd = 2'd3; id_valid = 1; id_jreg = 1; id_rs1 = 2'd3;
    chk("R3 jreg load c1", pack_exp(3'd3));
    step(); ex_valid = 0; ex_load = 0; wb_valid = 1; wb_load = 1; wb_rd = 2'd3;
    chk("R3 jreg load c2", pack_exp(3'd3));
    step(); wb_valid = 0;
    chk("R3 jreg load c3", pack_exp(3'd0));

    // R4 implicit reader in decode behind CSR write
    step(); clear();
    ex_valid = 1; ex_csr_ewr = 1; id_valid = 1; id_csr_ird = 1;
    chk("R4 csr in ex", pack_exp(3'd4));
    step(); ex_valid = 0; ex_csr_ewr = 0; wb_valid = 1; wb_csr_ewr = 1;
    chk("R4 csr in wb", pack_exp(3'd4));
    step(); wb_valid = 0;
    chk("R4 released", pack_exp(3'd0));

    // R5 implicit read in EX behind explicit read in WB
    step(); clear();
    ex_valid = 1; ex_csr_ird = 1; wb_valid = 1; wb_csr_erd = 1;
    chk("R5 ex implicit", pack_exp(3'd5));

    // R6 same and different address
    step(); clear();
    ex_valid = 1; ex_csr_erd = 1; ex_csr_addr = 2'd1;
    wb_valid = 1; wb_csr_ewr = 1; wb_csr_addr = 2'd1;
    chk("R6 same addr", pack_exp(3'd6));
    wb_csr_addr = 2'd2;
    chk("R6 other addr", pack_exp(3'd0));
    wb_csr_iwr = 1;
    chk("R6 implicit write", pack_exp(3'd6));

    // R8 EX rule wins over a concurrent load-use
    step(); clear();
    ex_valid = 1; ex_load = 1; ex_rd = 2'd1; ex_csr_ird = 1;
    id_valid = 1; id_rs1_en = 1; id_rs1 = 2'd1;
    wb_valid = 1; wb_csr_iwr = 1;
    chk("R8 ex over id", pack_exp(3'd5));

    // R9 invalid stages ignored
    ex_valid = 0; wb_valid = 0; id_valid = 0;
    chk("R9 invalid ignored", pack_exp(3'd0));

    // near-exhaustive random sweep over the small configuration
    s = 32'h1234_5678;
    for (int n = 0; n < 60000; n++) begin
      logic [7:0] e;
      step();
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      {id_valid, id_rs1_en, id_rs2_en, id_jreg, id_csr_ird, id_rs1, id_rs2} = s[10:0];
      {ex_valid, ex_load, ex_csr_erd, ex_csr_ewr, ex_csr_ird, ex_csr_iwr,
       ex_rd, ex_csr_addr} = s[20:11];
      {wb_valid, wb_load, wb_csr_erd, wb_csr_ewr, wb_csr_ird, wb_csr_iwr,
       wb_rd, wb_csr_addr} = {s[31:21], 1'b0} ^ {s[9:0]};
      e = model();
      chk({tag_of(e[2:0]), " sweep"}, e);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule